// File: doc/BRIEF.md
# Multiply-Divide-Accumulate Register Unit

This block is a small arithmetic engine that sits behind a byte-wide register port. A host loads a control byte and two 16-bit operands, one byte at a time. The operation runs when the upper byte of the second operand is written. There are three operations: a signed 16 by 16 multiply; a division of a signed dividend by an unsigned divisor, which returns both the quotient and the remainder; and a signed multiply that adds its product into a 40-bit running sum. The result is read back one byte at a time, and a status byte carries the accumulator overflow flag.

All arithmetic finishes in the cycle of the launching write, and the result register holds the outcome from the next clock edge on. A valid flag marks that the result register holds the output of a completed operation. After an operation the operands it used are cleared, as listed below. A host that keeps one operand between operations therefore has to reload the other one.

Top module: `mda_unit`

## Requirements
- R1: The control register is at address 0. Its bits 1:0 pick the operation: 0 is multiply, 1 is divide, and 2 or 3 is accumulate. The mode holds until the next control write.
- R2: A control write with bit 1 set clears the 40-bit result/accumulator, the overflow flag and the valid flag on the next clock edge.
- R3: The operands are byte registers: first operand low byte at address 1 and high byte at address 2, second operand low byte at address 3 and high byte at address 4. Only a write to address 4 launches an operation. Any other write leaves the result and the overflow flag unchanged.
- R4: Multiply places the signed 32-bit product of the two operands, sign-extended to 40 bits, in the result.
- R5: Divide takes the first operand as signed and the second as unsigned and truncates toward zero. The quotient goes to result bits 15:0, the remainder (two's complement, with the sign of the dividend) to bits 31:16, and bits 39:32 are zero. A zero divisor gives a result of zero.
- R6: After a multiply or an accumulate the second operand reads as zero. After a divide both operands are zero.
- R7: Accumulate adds the sign-extended signed product to the 40-bit sum modulo 2^40. Each accumulate sets the overflow flag to whether the exact sum fell outside 0 to 2^40-1. Multiply and divide leave the flag unchanged.
- R8: Read addresses 0 to 4 return result bytes from least to most significant. Address 5 returns the status byte, with overflow in bit 7 and zeros in bits 6:0. All other read addresses return 0.
- R9: After reset the result, the operands, the overflow flag and the valid flag are zero, and the mode is multiply.
- R10: The valid flag is high from the clock edge that follows a launch until the next clear or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 8 | Read data byte, combinational from rd_addr |
| res_valid | output | 1 | Result register holds a completed operation |

## Verification
The hardest cases to reach from the ports are accumulator overflow in both directions and the overflow flag dropping again on the next accumulate. Reaching 2^40 from zero with positive products would take about a thousand launches. The bench instead subtracts one from a cleared sum, which wraps below zero to 2^40-1 and sets the flag. It then adds one twice: the first addition reaches 2^40 and wraps to zero, and the second leaves the flag clear. The operand-clear rules are observed by reloading only one operand and checking that the result uses zero for the other.

// File: rtl/mda_pkg.sv
package mda_pkg;
    localparam int unsigned MDA_OP_W  = 16;
    localparam int unsigned MDA_ACC_W = 40;
    localparam int unsigned MDA_ADR_W = 4;

    // write map
    localparam logic [MDA_ADR_W-1:0] ADR_CTRL = 4'd0;
    localparam logic [MDA_ADR_W-1:0] ADR_A_LO = 4'd1;
    localparam logic [MDA_ADR_W-1:0] ADR_A_HI = 4'd2;
    localparam logic [MDA_ADR_W-1:0] ADR_B_LO = 4'd3;
    localparam logic [MDA_ADR_W-1:0] ADR_B_HI = 4'd4;
    // read map: result bytes at 0..4, status after them
    localparam logic [MDA_ADR_W-1:0] ADR_STAT = 4'd5;

    typedef enum logic [1:0] {
        MD_MUL  = 2'd0,
        MD_DIV  = 2'd1,
        MD_ACC  = 2'd2,
        MD_ACC3 = 2'd3
    } mda_mode_e;

    typedef struct packed {
        mda_mode_e             mode;
        logic [MDA_OP_W-1:0]   a;
        logic [MDA_OP_W-1:0]   b;
        logic [MDA_ACC_W-1:0]  acc;
        logic                  ovf;
        logic                  vld;
    } mda_state_t;
endpackage

// File: rtl/mda_arith.sv
module mda_arith
    import mda_pkg::*;
#(
    parameter int unsigned OP_W  = MDA_OP_W,
    parameter int unsigned ACC_W = MDA_ACC_W
) (
    input  mda_mode_e         mode,
    input  logic [OP_W-1:0]   opa,
    input  logic [OP_W-1:0]   opb,
    input  logic [ACC_W-1:0]  acc,
    output logic [ACC_W-1:0]  result,
    output logic              ovf_new
);
    localparam int unsigned PROD_W = 2 * OP_W;
    localparam int unsigned EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [OP_W:0]     dvd, dvs;
    logic signed [OP_W:0]     quo, rem;
    logic        [ACC_W:0]    sum_ext;
    logic                     dvs_zero;

    always_comb begin
        prod     = $signed(opa) * $signed(opb);
        dvs_zero = (opb == '0);
        dvd      = {opa[OP_W-1], opa};
        // substitute 1 for a zero divisor; the result is forced to 0 below
        dvs      = dvs_zero ? (OP_W+1)'(1) : {1'b0, opb};
        quo      = dvd / dvs;
        rem      = dvd % dvs;
        sum_ext  = {1'b0, acc} + {{(EXT_W+1){prod[PROD_W-1]}}, prod};
        ovf_new  = sum_ext[ACC_W];
        unique case (mode)
            MD_MUL:  result = {{EXT_W{prod[PROD_W-1]}}, prod};
            MD_DIV:  result = dvs_zero ? '0
                             : {{EXT_W{1'b0}}, rem[OP_W-1:0], quo[OP_W-1:0]};
            default: result = sum_ext[ACC_W-1:0];
        endcase
    end
endmodule

// File: rtl/mda_rdmux.sv
module mda_rdmux
    import mda_pkg::*;
#(
    parameter int unsigned ACC_W  = MDA_ACC_W,
    parameter int unsigned ADDR_W = MDA_ADR_W,
    parameter int unsigned DATA_W = 8
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ACC_W-1:0]  acc,
    input  logic              ovf,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned N_BYTES = ACC_W / DATA_W;

    logic [DATA_W-1:0] bytes [N_BYTES];

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        assign bytes[g] = acc[g*DATA_W +: DATA_W];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_STAT) begin
            rd_data[DATA_W-1] = ovf;
        end else if (32'(rd_addr) < N_BYTES) begin
            rd_data = bytes[rd_addr];
        end
    end
endmodule

// File: rtl/mda_unit.sv
module mda_unit
    import mda_pkg::*;
#(
    parameter int unsigned ADDR_W = MDA_ADR_W,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              res_valid
);
    localparam int unsigned OP_W  = MDA_OP_W;
    localparam int unsigned ACC_W = MDA_ACC_W;
    localparam int unsigned HI_W  = OP_W - DATA_W;

    mda_state_t st_d, st_q;
    logic              launch;
    logic [OP_W-1:0]   opb_full;
    logic [ACC_W-1:0]  arith_res;
    logic              arith_ovf;

    assign opb_full = {wr_data[HI_W-1:0], st_q.b[DATA_W-1:0]};

    mda_arith #(.OP_W(OP_W), .ACC_W(ACC_W)) i_arith (
        .mode    (st_q.mode),
        .opa     (st_q.a),
        .opb     (opb_full),
        .acc     (st_q.acc),
        .result  (arith_res),
        .ovf_new (arith_ovf)
    );

    always_comb begin
        st_d   = st_q;
        launch = 1'b0;
        if (wr_en) begin
            unique case (wr_addr)
                ADR_CTRL: begin
                    st_d.mode = mda_mode_e'(wr_data[1:0]);
                    if (wr_data[1]) begin
                        st_d.acc = '0;
                        st_d.ovf = 1'b0;
                        st_d.vld = 1'b0;
                    end
                end
                ADR_A_LO: st_d.a[DATA_W-1:0]  = wr_data;
                ADR_A_HI: st_d.a[OP_W-1:DATA_W] = wr_data[HI_W-1:0];
                ADR_B_LO: st_d.b[DATA_W-1:0]  = wr_data;
                ADR_B_HI: launch = 1'b1;
                default:  ;
            endcase
        end
        if (launch) begin
            st_d.acc = arith_res;
            st_d.vld = 1'b1;
            st_d.b   = '0;
            if (st_q.mode == MD_DIV) begin
                st_d.a = '0;
            end
            if (st_q.mode == MD_ACC || st_q.mode == MD_ACC3) begin
                st_d.ovf = arith_ovf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_MUL, a: '0, b: '0, acc: '0, ovf: 1'b0, vld: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    mda_rdmux #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rdmux (
        .rd_addr (rd_addr),
        .acc     (st_q.acc),
        .ovf     (st_q.ovf),
        .rd_data (rd_data)
    );

    assign res_valid = st_q.vld;
endmodule

// File: rtl/mda_unit_chk.sv
module mda_unit_chk
    import mda_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [MDA_ADR_W-1:0]  wr_addr,
    input logic [7:0]            wr_data,
    input logic [MDA_ADR_W-1:0]  rd_addr,
    input logic [7:0]            rd_data,
    input logic [1:0]            mode,
    input logic [MDA_OP_W-1:0]   a,
    input logic [MDA_OP_W-1:0]   b,
    input logic [MDA_ACC_W-1:0]  acc,
    input logic                  ovf,
    input logic                  vld
);
    logic launch;
    assign launch = wr_en && (wr_addr == ADR_B_HI);

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == ADR_CTRL && wr_data[1] |=> acc == '0 && !ovf && !vld); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(acc) && $stable(ovf)); // R3
    AST_NONLAUNCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == ADR_A_LO || wr_addr == ADR_A_HI || wr_addr == ADR_B_LO)
        |=> $stable(acc) && $stable(ovf)); // R3
    AST_DIV_CLEARS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        launch && mode == 2'd1 |=> a == '0 && b == '0); // R6
    AST_MUL_CLEARS_B: assert property (@(posedge clk) disable iff (!rst_n)
        launch && mode != 2'd1 |=> b == '0); // R6
    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        launch && mode == 2'd1 && b[7:0] == 8'd0 && wr_data == 8'd0 |=> acc == '0); // R5
    AST_OVF_ONLY_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        launch && mode[1] == 1'b0 |=> $stable(ovf)); // R7
    AST_VALID_AFTER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> vld); // R10
    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == ADR_STAT |-> rd_data[6:0] == 7'd0); // R8
endmodule

bind mda_unit mda_unit_chk i_mda_unit_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .mode    (st_q.mode),
    .a       (st_q.a),
    .b       (st_q.b),
    .acc     (st_q.acc),
    .ovf     (st_q.ovf),
    .vld     (st_q.vld)
);

// File: tb/test_mda_unit.sv
module test_mda_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       res_valid;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    mda_unit i_mda_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .res_valid(res_valid)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] ad, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ad; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] ad, output logic [7:0] d);
        rd_addr = ad;
        #1;
        d = rd_data;
    endtask

    task automatic get_res(output logic [39:0] r);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] d;
            rd(4'(i), d);
            r[8*i +: 8] = d;
        end
    endtask

    task automatic get_ovf(output logic o);
        logic [7:0] d;
        rd(4'd5, d);
        o = d[7];
    endtask

    task automatic load_go(input logic [15:0] a, input logic [15:0] b);
        wr(4'd1, a[7:0]); wr(4'd2, a[15:8]);
        wr(4'd3, b[7:0]); wr(4'd4, b[15:8]);
    endtask

    function automatic logic [39:0] exp_mul(input logic [15:0] a, input logic [15:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        return p[39:0];
    endfunction

    function automatic logic [39:0] exp_div(input logic [15:0] a, input logic [15:0] b);
        longint q, r, n, d;
        if (b == 16'd0) return 40'd0;
        n = longint'($signed(a));
        d = longint'({48'd0, b});
        q = n / d;
        r = n % d;
        return {8'd0, r[15:0], q[15:0]};
    endfunction

    task automatic t_reset;
        logic [39:0] r; logic o;
        get_res(r); get_ovf(o);
        chk("R9", "result after reset", r, 0);
        chk("R9", "overflow after reset", o, 0);
        chk("R9", "valid after reset", res_valid, 0);
        // default mode is multiply: launch without a control write
        load_go(16'd7, 16'd6);
        get_res(r);
        chk("R9", "default mode multiplies", r, 40'd42);
        chk("R10", "valid after launch", res_valid, 1);
    endtask

    task automatic t_multiply;
        logic [15:0] av [4] = '{16'h1234, 16'hFFFD, 16'h8000, 16'h7FFF};
        logic [15:0] bv [4] = '{16'h0100, 16'h0005, 16'h8000, 16'h8000};
        logic [39:0] r;
        wr(4'd0, 8'h00);
        for (int i = 0; i < 4; i++) begin
            load_go(av[i], bv[i]);
            get_res(r);
            chk("R4", $sformatf("multiply %0h*%0h", av[i], bv[i]), r, exp_mul(av[i], bv[i]));
        end
    endtask

    task automatic t_divide;
        logic [15:0] av [4] = '{16'd100, 16'hFFF9, 16'h8000, 16'h1234};
        logic [15:0] bv [4] = '{16'd7, 16'd2, 16'hFFFF, 16'h0001};
        logic [39:0] r;
        wr(4'd0, 8'h01);
        for (int i = 0; i < 4; i++) begin
            load_go(av[i], bv[i]);
            get_res(r);
            chk("R5", $sformatf("divide %0h/%0h", av[i], bv[i]), r, exp_div(av[i], bv[i]));
        end
        load_go(16'h4321, 16'h0000);
        get_res(r);
        chk("R5", "zero divisor", r, 40'd0);
        chk("R1", "mode held across launches", r, exp_div(16'h4321, 16'h0));
    endtask

    task automatic t_operand_clear;
        logic [39:0] r;
        // divide clears both: reload divisor only -> dividend is zero
        wr(4'd0, 8'h01);
        load_go(16'd50, 16'd3);
        wr(4'd4, 8'h01);
        get_res(r);
        chk("R6", "dividend cleared after divide", r, exp_div(16'd0, 16'h0100));
        // multiply clears second operand only
        wr(4'd0, 8'h00);
        load_go(16'd3, 16'h0005);
        wr(4'd4, 8'h01);
        get_res(r);
        chk("R6", "second low byte cleared, first kept", r, exp_mul(16'd3, 16'h0100));
    endtask

    task automatic t_accumulate;
        logic [39:0] r; logic o;
        wr(4'd0, 8'h02);
        get_res(r); get_ovf(o);
        chk("R2", "accumulate entry clears sum", r, 40'd0);
        chk("R10", "clear drops valid", res_valid, 0);
        load_go(16'd1000, 16'd300);
        load_go(16'hFFFE, 16'd50);
        get_res(r); get_ovf(o);
        chk("R7", "sum of two products", r, 40'd299900);
        chk("R7", "no overflow in range", o, 0);
        wr(4'd0, 8'h03);
        load_go(16'hFFFF, 16'd1);
        get_res(r); get_ovf(o);
        chk("R7", "wrap below zero", r, 40'hFF_FFFF_FFFF);
        chk("R7", "overflow on underflow", o, 1);
        load_go(16'd1, 16'd1);
        get_res(r); get_ovf(o);
        chk("R7", "wrap at 2^40", r, 40'd0);
        chk("R7", "overflow on carry", o, 1);
        // multiply leaves the flag alone
        wr(4'd0, 8'h00);
        load_go(16'd2, 16'd2);
        get_ovf(o);
        chk("R7", "multiply keeps overflow", o, 1);
        wr(4'd0, 8'h02);
        get_ovf(o);
        chk("R2", "clear drops overflow", o, 0);
        load_go(16'hFFFF, 16'd1);
        load_go(16'd1, 16'd1);
        load_go(16'd1, 16'd1);
        get_res(r); get_ovf(o);
        chk("R7", "overflow recomputed each accumulate", o, 0);
        chk("R7", "sum after recovery", r, 40'd1);
    endtask

    task automatic t_nonlaunch;
        logic [39:0] r0, r1;
        wr(4'd0, 8'h00);
        load_go(16'd9, 16'd9);
        get_res(r0);
        wr(4'd1, 8'h55); wr(4'd2, 8'h66); wr(4'd3, 8'h77); wr(4'd9, 8'hFF);
        get_res(r1);
        chk("R3", "operand writes do not launch", r1, r0);
        wr(4'd4, 8'h00);
        get_res(r1);
        chk("R3", "high byte launches with loaded bytes", r1, exp_mul(16'h6655, 16'h0077));
    endtask

    task automatic t_readmap;
        logic [7:0] d;
        wr(4'd0, 8'h00);
        load_go(16'hFFFF, 16'd1);
        rd(4'd4, d);
        chk("R8", "byte 4 is top of result", d, 8'hFF);
        rd(4'd0, d);
        chk("R8", "byte 0 is bottom of result", d, 8'hFF);
        rd(4'd9, d);
        chk("R8", "unmapped read is zero", d, 8'h00);
        rd(4'd5, d);
        chk("R8", "status without overflow", d, 8'h00);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_multiply();
        t_divide();
        t_operand_clear();
        t_accumulate();
        t_nonlaunch();
        t_readmap();
        finish_run();
    end
endmodule